// File: doc/BRIEF.md
# Asynchronous Strobe-Driven Register Port

This block is a register-access slave for a processor bus that has no clock of its own. The processor selects the block with an active-low chip select. It sets an 11-bit address and moves 32-bit words with active-low read and write strobes. The block answers each access by pulling an active-low ready line. Every strobe first crosses into the block's clock through a two-flop synchroniser, and edge detection runs on the synchronised copies.

For a write, the address is captured when the synchronised write strobe asserts. The data is captured when that strobe releases. The block then issues a one-cycle write into its internal bank and drives ready low. For a read, the address is captured when the read strobe asserts, and one cycle later the selected word is fetched into an output register. Ready then goes low to mark the data valid. The output enable for the data bus follows chip select and read strobe together.

The bank holds 64 words of 32 bits, indexed by the low six address bits. Any address with a non-zero bit above bit 5 lies outside the bank.

Top module: `async_reg_port`

## Requirements
- R1: While the synchronous active-high reset is high, and after it, ready (active low) is high and the data output enable is low.
- R2: On a write, the address used is the one present when the write strobe asserts. Changing the address bus afterwards, while the strobe is still low, has no effect on which word is written.
- R3: On a write, the data stored is the value on the data bus when the write strobe de-asserts. Earlier values driven during the strobe are not stored.
- R4: After a write completes, ready goes low. It stays low while chip select remains low, and returns high once chip select de-asserts.
- R5: A read returns the stored word of the addressed location with ready low. Ready stays low while chip select and the read strobe remain asserted, and returns high when the read strobe de-asserts.
- R6: Addresses 0x040 to 0x7FF read as zero, and writes to them change no word of the bank (no aliasing onto addresses 0x000 to 0x03F).
- R7: A write whose chip select de-asserts before the write strobe is released is abandoned. No word changes and ready stays high.
- R8: The data output enable is high only while chip select and the read strobe are both low.
- R9: Reset clears every word of the bank to zero.
- R10: Writes to the first (0x000) and last (0x03F) locations, and to locations in between, with distinct data patterns, are each read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low, asynchronous |
| rdN | input | 1 | Read strobe, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 11 | Word address |
| dataIn | input | 32 | Write data from the processor |
| dataOut | output | 32 | Read data to the processor |
| dataOe | output | 1 | High when dataOut should drive the bus |
| rdyN | output | 1 | Ready acknowledge, active low |

## Verification
Writes are driven with the address changed and the data replaced while the write strobe is still low. Only capture at strobe assertion for the address and at strobe release for the data gives the expected read-back. Reads of words written with walking-ones, all-ones and alternating patterns at the lowest, highest and a middle index separate correct indexing from stuck or swapped bits. A write above the bank followed by a read of the aliased low location shows whether the range decode is complete. A write abandoned by releasing chip select early, and a reset issued after data is stored, show that no stray write reaches the bank.

// File: rtl/arp_pkg.sv
package arp_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capAddr;
    logic capData;
    logic wrEn;
    logic rdEn;
  } arpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_WAIT,
    ST_WR_COMMIT,
    ST_WR_ACK,
    ST_RD_FETCH,
    ST_RD_ACK
  } arpState_e;

endpackage

// File: rtl/arp_ctrl.sv
module arp_ctrl
  import arp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  output arpStrobe_t strobes,
  output logic       rdyN
);

  localparam int NSIG = 3;  // bit 0 chip select, bit 1 read, bit 2 write

  logic [NSIG-1:0] stage [SYNC_STAGES];
  logic [NSIG-1:0] syncPrev;
  logic [NSIG-1:0] syncNow;

  // Synchroniser chain on active-high versions of the strobes
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          stage[s] <= '0;
        end else if (s == 0) begin
          stage[s] <= ~{wrN, rdN, csN};
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncNow = stage[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) syncPrev <= '0;
    else     syncPrev <= syncNow;
  end

  logic csS, rdS, wrS, rdRise, wrRise, wrFall;
  assign csS    = syncNow[0];
  assign rdS    = syncNow[1];
  assign wrS    = syncNow[2];
  assign rdRise = rdS & ~syncPrev[1];
  assign wrRise = wrS & ~syncPrev[2];
  assign wrFall = ~wrS & syncPrev[2];

  arpState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (csS && wrRise) begin
          strobes.capAddr = 1'b1;
          stateNext       = ST_WR_WAIT;
        end else if (csS && rdRise) begin
          strobes.capAddr = 1'b1;
          stateNext       = ST_RD_FETCH;
        end
      end
      ST_WR_WAIT: begin
        if (!csS) begin
          stateNext = ST_IDLE;
        end else if (wrFall) begin
          strobes.capData = 1'b1;
          stateNext       = ST_WR_COMMIT;
        end
      end
      ST_WR_COMMIT: begin
        strobes.wrEn = 1'b1;
        stateNext    = csS ? ST_WR_ACK : ST_IDLE;
      end
      ST_WR_ACK: begin
        if (!csS) stateNext = ST_IDLE;
      end
      ST_RD_FETCH: begin
        strobes.rdEn = 1'b1;
        stateNext    = csS ? ST_RD_ACK : ST_IDLE;
      end
      ST_RD_ACK: begin
        if (!csS || !rdS) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign rdyN = !((state == ST_WR_ACK) || (state == ST_RD_ACK));

endmodule

// File: rtl/arp_datapath.sv
module arp_datapath
  import arp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  arpStrobe_t        strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] bank [DEPTH];
  logic              inRange;
  logic [IDX_W-1:0]  idx;

  assign inRange = ((addrReg >> IDX_W) == '0);
  assign idx     = addrReg[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.capAddr) addrReg <= addrIn;
      if (strobes.capData) dataReg <= dataIn;
    end
  end

  // One register per bank word
  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          bank[w] <= '0;
        else if (strobes.wrEn && inRange && (idx == IDX_W'(w)))
          bank[w] <= dataReg;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      rdData <= '0;
    else if (strobes.rdEn)
      rdData <= inRange ? bank[idx] : '0;
  end

endmodule

// File: rtl/async_reg_port.sv
module async_reg_port
  import arp_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdyN
);

  arpStrobe_t strobes;

  arp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .strobes (strobes),
    .rdyN    (rdyN)
  );

  arp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .addrIn  (addr),
    .dataIn  (dataIn),
    .rdData  (dataOut)
  );

  // Bus drive window follows the pads directly
  assign dataOe = ~csN & ~rdN;

endmodule

// File: rtl/arp_checker.sv
module arp_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              csN,
  input logic              rdyN,
  input logic [DATA_W-1:0] dataOut,
  input logic              wrReq,
  input logic              rdReq
);

  // R4 / R5: the register bank sees at most one request kind per cycle
  a_r5_req_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wrReq && rdReq));

  // R4: a write request lasts exactly one cycle
  a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
    wrReq |=> !wrReq);

  // R4 / R5: ready only falls right after a bank request
  a_r4_rdy_after_req: assert property (@(posedge clk) disable iff (rst)
    $fell(rdyN) |-> $past(wrReq || rdReq));

  // R5: read data holds while ready is held low
  a_r5_data_stable: assert property (@(posedge clk) disable iff (rst)
    (!rdyN && !$past(rdyN)) |-> $stable(dataOut));

  // R4: ready is high once chip select has been inactive for several cycles
  a_r4_rdy_idle_cs: assert property (@(posedge clk) disable iff (rst)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3) && $past(csN, 4)) |-> rdyN);

endmodule

bind async_reg_port arp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .csN     (csN),
  .rdyN    (rdyN),
  .dataOut (dataOut),
  .wrReq   (strobes.wrEn),
  .rdReq   (strobes.rdEn)
);

// File: tb/tb_async_reg_port.sv
module tb_async_reg_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csN = 1'b1;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [10:0] addr = '0;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataOe;
  logic        rdyN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  async_reg_port dut (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .rdyN(rdyN)
  );

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitRdy(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (!rdyN) seen = 1'b1;
    end
    check(seen, tag, {31'b0, rdyN}, 32'h0);
  endtask

  // Write: lateAddr replaces the address after the strobe asserts,
  // dataEarly is replaced by dataLate before the strobe releases.
  task automatic doWrite(input logic [10:0] a, input logic [10:0] lateAddr,
                         input logic [31:0] dataEarly, input logic [31:0] dataLate);
    csN = 1'b0; addr = a;
    waitCyc(3);
    wrN = 1'b0;
    waitCyc(6);
    addr = lateAddr; dataIn = dataEarly;
    waitCyc(4);
    dataIn = dataLate;
    waitCyc(3);
    wrN = 1'b1;
    waitRdy("R4 ready after write");
    dataIn = 32'hDEAD_0000;
    waitCyc(5);
    check(rdyN == 1'b0, "R4 ready held while cs low", {31'b0, rdyN}, 32'h0);
    csN = 1'b1;
    waitCyc(5);
    check(rdyN == 1'b1, "R4 ready released after cs", {31'b0, rdyN}, 32'h1);
  endtask

  task automatic doRead(input logic [10:0] a, input logic [31:0] exp, input string tag);
    csN = 1'b0; addr = a;
    waitCyc(2);
    rdN = 1'b0;
    waitRdy({tag, " ready on read"});
    check(dataOut == exp, tag, dataOut, exp);
    check(dataOe == 1'b1, "R8 oe during read", {31'b0, dataOe}, 32'h1);
    waitCyc(3);
    check(rdyN == 1'b0, "R5 ready held while rd low", {31'b0, rdyN}, 32'h0);
    rdN = 1'b1;
    waitCyc(5);
    check(rdyN == 1'b1, "R5 ready released after rd", {31'b0, rdyN}, 32'h1);
    check(dataOe == 1'b0, "R8 oe off with rd high", {31'b0, dataOe}, 32'h0);
    csN = 1'b1;
    waitCyc(3);
  endtask

  task automatic testReset();
    waitCyc(2);
    check(rdyN == 1'b1, "R1 ready in reset", {31'b0, rdyN}, 32'h1);
    check(dataOe == 1'b0, "R1 oe in reset", {31'b0, dataOe}, 32'h0);
    rst = 1'b0;
    waitCyc(3);
    check(rdyN == 1'b1, "R1 ready after reset", {31'b0, rdyN}, 32'h1);
    check(dataOe == 1'b0, "R1 oe after reset", {31'b0, dataOe}, 32'h0);
  endtask

  task automatic testAddrData();
    // address 0x005 latched, then bus moved to 0x009; data 0x1111 replaced by 0x2222
    doWrite(11'h005, 11'h009, 32'h1111_1111, 32'h2222_2222);
    doRead(11'h005, 32'h2222_2222, "R3 data latched at strobe release");
    doRead(11'h009, 32'h0, "R2 later address not written");
  endtask

  task automatic testPatterns();
    doWrite(11'h000, 11'h000, 32'h0, 32'h8040_2010);
    doWrite(11'h03F, 11'h03F, 32'h0, 32'hFFFF_FFFF);
    doWrite(11'h02A, 11'h02A, 32'h0, 32'hA5A5_5A5A);
    doRead(11'h000, 32'h8040_2010, "R10 first word");
    doRead(11'h03F, 32'hFFFF_FFFF, "R10 last word");
    doRead(11'h02A, 32'hA5A5_5A5A, "R10 middle word");
  endtask

  task automatic testRange();
    doWrite(11'h040, 11'h040, 32'h0, 32'h1234_5678);
    doWrite(11'h7FF, 11'h7FF, 32'h0, 32'h0BAD_F00D);
    doRead(11'h040, 32'h0, "R6 out-of-range reads zero");
    doRead(11'h000, 32'h8040_2010, "R6 no alias at 0x000");
    doRead(11'h03F, 32'hFFFF_FFFF, "R6 no alias at 0x03F");
  endtask

  task automatic testAbandon();
    bit sawRdy = 1'b0;
    csN = 1'b0; addr = 11'h02A;
    waitCyc(3);
    wrN = 1'b0;
    waitCyc(6);
    dataIn = 32'h7777_7777;
    waitCyc(3);
    csN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!rdyN) sawRdy = 1'b1;
    end
    wrN = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!rdyN) sawRdy = 1'b1;
    end
    check(!sawRdy, "R7 no ready on abandoned write", {31'b0, sawRdy}, 32'h0);
    check(dataOe == 1'b0, "R8 oe off with cs high", {31'b0, dataOe}, 32'h0);
    doRead(11'h02A, 32'hA5A5_5A5A, "R7 abandoned write left word");
  endtask

  task automatic testResetClears();
    @(negedge clk); rst = 1'b1;
    waitCyc(3);
    rst = 1'b0;
    waitCyc(3);
    doRead(11'h000, 32'h0, "R9 reset clears word 0");
    doRead(11'h005, 32'h0, "R9 reset clears word 5");
  endtask

  initial begin
    testReset();
    testAddrData();
    testPatterns();
    testRange();
    testAbandon();
    testResetClears();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule